// File: doc/BRIEF.md
# Link Low-Power Substate Controller

This block is the per-port sequencer that takes an idle serial link deeper than basic L1. Once the link trainer reports that L1 has been entered, the controller can release its reference-clock request. This first stage keeps the bias on with the clock off. It can then go further into a bias-off stage in which the transmit and receive common-mode bias is removed. A wake event reverses the path in a fixed order. A wake event is a pending transaction or the link partner asking for the clock. The controller requests the clock again, waits for the clock to be reported stable, restores the bias and waits out the programmed power-on time. Only then does it ask the link trainer to leave L1 through Recovery.

Analog work happens outside the block and arrives as handshake inputs: reference-clock stable and bias ramp-down done. A single-cycle microsecond tick drives both programmable waits. The first wait holds the bias on for a programmed time after bias-off entry starts. The second is the bias restore time on exit. Each wait counter is reloaded whenever its wait state is entered. A 4-bit status output reports the current substate so that the order of transitions can be observed.

Top module: `lpss_ctrl`

## Requirements
- R1: After synchronous reset, the status reads 0 (link not in L1), the clock-request release is low, the bias enable is high and the exit request is low.
- R2: From status 0 the block moves to status 1 (basic L1, clock on) on the cycle after the L1-entered input is seen high. From status 1 it returns to status 0 when that input is low.
- R3: From status 1 the block moves to status 2 (clock off, bias on) only when L1 is entered, the first-stage enable is set and no wake is present. The clock-request release output is high exactly in statuses 2 through 5.
- R4: Status 3 (bias-off entry, hold) is entered only from status 2. This happens when the second-stage enable is set, the entry-permitted flag is high and the training-state input (Configuration or Recovery) is low. Otherwise the block stays in status 2.
- R5: In status 3 the bias stays enabled until exactly the programmed hold count of microsecond ticks has been consumed. The block then moves to status 4 (bias ramping down) with the bias enable low.
- R6: Status 4 moves to status 5 (clock off, bias off) when the ramp-done input is high.
- R7: A wake in any of statuses 2 to 5 moves the block to status 6 (clock re-request, release low). A wake in status 1 moves it directly to status 8.
- R8: Status 6 holds until reference-clock stable is high. It then goes to status 7 if the bias had been removed and to status 8 otherwise. The bias stays off in status 6 if it had been removed.
- R9: Status 7 enables the bias and holds for exactly the programmed power-on count of microsecond ticks before moving to status 8. Wake has no effect there.
- R10: In status 8 the L1-exit request is high. It stays high until the L1-entered input falls, at which point the block returns to status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_entered | input | 1 | Link trainer is in L1 |
| us_tick | input | 1 | Single-cycle microsecond pulse |
| l11_en | input | 1 | First-stage (clock off) enable |
| l12_en | input | 1 | Second-stage (bias off) enable |
| train_cfg_rec | input | 1 | Link trainer is in Configuration or Recovery |
| l12_permit | input | 1 | Latency threshold allows the bias-off stage |
| txn_pending | input | 1 | Transaction waiting (wake) |
| partner_clk_req | input | 1 | Link partner requests the clock (wake) |
| refclk_stable | input | 1 | Reference clock reported stable |
| bias_down_done | input | 1 | Common-mode ramp-down finished |
| cm_hold_us | input | HOLD_W | Hold before bias removal, in microseconds |
| pwr_on_us | input | PON_W | Bias restore wait, in microseconds |
| clk_req_release | output | 1 | High: reference clock not needed |
| cm_bias_en | output | 1 | Common-mode bias enable |
| l1_exit_req | output | 1 | Request to leave L1 through Recovery |
| substate | output | 4 | Current substate code |

## Verification
The bench builds the controller with its default widths: an 8-bit hold field and a 10-bit power-on field. It programs hold and power-on counts from 0 to 20 ticks and pulses the microsecond tick every fourth cycle. Both timed waits therefore complete many times within the run. The zero-count case, where a wait ends after one cycle, is reached as well. A wake can land in every substate, including the middle of the hold and of the ramp-down, so both exit paths are exercised: the one that skips the bias wait and the one that includes it.

// File: rtl/lpss_pkg.sv
package lpss_pkg;

    typedef enum logic [3:0] {
        SS_DOWN  = 4'd0,
        SS_L10   = 4'd1,
        SS_L11   = 4'd2,
        SS_HOLD  = 4'd3,
        SS_RAMP  = 4'd4,
        SS_IDLE  = 4'd5,
        SS_XCLK  = 4'd6,
        SS_XBIAS = 4'd7,
        SS_XREQ  = 4'd8
    } ss_e;

    typedef struct packed {
        logic l1_in;
        logic en_l11;
        logic en_l12;
        logic training;
        logic permit;
        logic wake;
        logic refclk_ok;
        logic ramp_done;
    } ss_cond_t;

    function automatic logic clk_off_state(ss_e s);
        return (s == SS_L11) || (s == SS_HOLD) || (s == SS_RAMP) || (s == SS_IDLE);
    endfunction

endpackage

// File: rtl/lpss_timer.sv
module lpss_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load)                    cnt_q <= load_val;
        else if (tick && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5
    cnt_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt_q <= $past(cnt_q));

    // R9
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/lpss_fsm.sv
module lpss_fsm
    import lpss_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ss_cond_t cond,
    input  logic     hold_zero,
    input  logic     pon_zero,
    output logic     hold_load,
    output logic     pon_load,
    output ss_e      state,
    output logic     bias_off
);
    ss_e  state_q, nxt;
    logic bias_off_q;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            SS_DOWN:  if (cond.l1_in) nxt = SS_L10;
            SS_L10: begin
                if (!cond.l1_in)      nxt = SS_DOWN;
                else if (cond.wake)   nxt = SS_XREQ;
                else if (cond.en_l11) nxt = SS_L11;
            end
            SS_L11: begin
                if (cond.wake) nxt = SS_XCLK;
                else if (cond.en_l12 && cond.permit && !cond.training) nxt = SS_HOLD;
            end
            SS_HOLD: begin
                if (cond.wake)      nxt = SS_XCLK;
                else if (hold_zero) nxt = SS_RAMP;
            end
            SS_RAMP: begin
                if (cond.wake)           nxt = SS_XCLK;
                else if (cond.ramp_done) nxt = SS_IDLE;
            end
            SS_IDLE:  if (cond.wake) nxt = SS_XCLK;
            SS_XCLK:  if (cond.refclk_ok) nxt = bias_off_q ? SS_XBIAS : SS_XREQ;
            SS_XBIAS: if (pon_zero) nxt = SS_XREQ;
            SS_XREQ:  if (!cond.l1_in) nxt = SS_DOWN;
            default:  nxt = SS_DOWN;
        endcase
    end

    assign hold_load = (nxt == SS_HOLD)  && (state_q != SS_HOLD);
    assign pon_load  = (nxt == SS_XBIAS) && (state_q != SS_XBIAS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SS_DOWN;
            bias_off_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (nxt == SS_RAMP && state_q != SS_RAMP) bias_off_q <= 1'b1;
            else if (pon_load)                        bias_off_q <= 1'b0;
        end
    end

    assign state    = state_q;
    assign bias_off = bias_off_q;

    // R4
    hold_only_from_l11_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != SS_L11 && state_q != SS_HOLD) |=> state_q != SS_HOLD);

    // R4
    no_entry_in_training_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_L11 && cond.training) |=> state_q != SS_HOLD);

    // R5
    hold_before_ramp_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_HOLD && !hold_zero && !cond.wake) |=> state_q == SS_HOLD);

    // R5
    bias_kept_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_HOLD) |-> !bias_off_q);

    // R7
    wake_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_off_state(state_q) && cond.wake) |=> state_q == SS_XCLK);

    // R8
    clk_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_XCLK && !cond.refclk_ok) |=> state_q == SS_XCLK);

    // R9
    pon_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_XBIAS && !pon_zero) |=> state_q == SS_XBIAS);

endmodule

// File: rtl/lpss_ctrl.sv
module lpss_ctrl
    import lpss_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int PON_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l1_entered,
    input  logic              us_tick,
    input  logic              l11_en,
    input  logic              l12_en,
    input  logic              train_cfg_rec,
    input  logic              l12_permit,
    input  logic              txn_pending,
    input  logic              partner_clk_req,
    input  logic              refclk_stable,
    input  logic              bias_down_done,
    input  logic [HOLD_W-1:0] cm_hold_us,
    input  logic [PON_W-1:0]  pwr_on_us,
    output logic              clk_req_release,
    output logic              cm_bias_en,
    output logic              l1_exit_req,
    output logic [3:0]        substate
);
    ss_cond_t cond;
    ss_e      state;
    logic     hold_load, pon_load, hold_zero, pon_zero, bias_off;

    always_comb begin
        cond.l1_in     = l1_entered;
        cond.en_l11    = l11_en;
        cond.en_l12    = l12_en;
        cond.training  = train_cfg_rec;
        cond.permit    = l12_permit;
        cond.wake      = txn_pending | partner_clk_req;
        cond.refclk_ok = refclk_stable;
        cond.ramp_done = bias_down_done;
    end

    lpss_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cond      (cond),
        .hold_zero (hold_zero),
        .pon_zero  (pon_zero),
        .hold_load (hold_load),
        .pon_load  (pon_load),
        .state     (state),
        .bias_off  (bias_off)
    );

    lpss_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (hold_load),
        .load_val (cm_hold_us),
        .tick     (us_tick),
        .zero     (hold_zero)
    );

    lpss_timer #(.W(PON_W)) u_pon_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (pon_load),
        .load_val (pwr_on_us),
        .tick     (us_tick),
        .zero     (pon_zero)
    );

    assign clk_req_release = clk_off_state(state);
    assign cm_bias_en      = !bias_off;
    assign l1_exit_req     = (state == SS_XREQ);
    assign substate        = state;

    // R10
    exit_req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_exit_req && l1_entered) |=> l1_exit_req);

    // R8
    bias_off_until_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (!cm_bias_en && substate != 4'd7) |=> (!cm_bias_en || substate == 4'd7));

endmodule

// File: tb/tb_lpss_ctrl.sv
module tb_lpss_ctrl;
    localparam int HW = 8;
    localparam int PW = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, l1_entered, us_tick, l11_en, l12_en, train, permit, txn, partner, refclk, rampd;
    logic [HW-1:0] cm_hold;
    logic [PW-1:0] pon;
    logic clk_rel, bias_en, exit_req;
    logic [3:0] substate;

    lpss_ctrl #(.HOLD_W(HW), .PON_W(PW)) dut (
        .clk(clk), .rst(rst), .l1_entered(l1_entered), .us_tick(us_tick),
        .l11_en(l11_en), .l12_en(l12_en), .train_cfg_rec(train), .l12_permit(permit),
        .txn_pending(txn), .partner_clk_req(partner), .refclk_stable(refclk),
        .bias_down_done(rampd), .cm_hold_us(cm_hold), .pwr_on_us(pon),
        .clk_req_release(clk_rel), .cm_bias_en(bias_en), .l1_exit_req(exit_req),
        .substate(substate)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int pre_st = 0, hold_ticks = 0, hold_n = 0, pon_ticks = 0, pon_n = 0;
    bit gone = 0;
    logic p_l1, p_en11, p_en12, p_train, p_permit, p_wake, p_ref, p_ramp, p_tick;
    int p_hold, p_pon;

    task automatic chk(string r, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    function automatic string req_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            default: return "R10";
        endcase
    endfunction

    // expected next substate; alt >= 0 marks a timer-dependent alternative
    task automatic exp_next(output int e, output int alt);
        alt = -1;
        case (pre_st)
            0: e = p_l1 ? 1 : 0;
            1: e = !p_l1 ? 0 : p_wake ? 8 : p_en11 ? 2 : 1;
            2: e = p_wake ? 6 : (p_en12 && p_permit && !p_train) ? 3 : 2;
            3: begin e = p_wake ? 6 : 3; if (!p_wake) alt = 4; end
            4: e = p_wake ? 6 : p_ramp ? 5 : 4;
            5: e = p_wake ? 6 : 5;
            6: e = p_ref ? (gone ? 7 : 8) : 6;
            7: begin e = 7; alt = 8; end
            default: e = p_l1 ? 8 : 0;
        endcase
    endtask

    task automatic mon();
        int st, e, alt;
        st = int'(substate);
        exp_next(e, alt);
        n_cmp++;
        if (st != e && !(alt >= 0 && st == alt)) begin
            n_bad++;
            $display("FAIL %s: transition from %0d actual %0d expected %0d", req_of(pre_st), pre_st, st, e);
        end
        if (pre_st != 3 && st == 3) begin hold_ticks = 0; hold_n = p_hold; end
        else if (pre_st == 3 && st == 3 && p_tick) hold_ticks++;
        if (pre_st == 3 && st == 4) chk("R5 hold ticks", hold_ticks, hold_n);
        if (pre_st != 7 && st == 7) begin pon_ticks = 0; pon_n = p_pon; end
        else if (pre_st == 7 && st == 7 && p_tick) pon_ticks++;
        if (pre_st == 7 && st == 8) chk("R9 power-on ticks", pon_ticks, pon_n);
        if (st == 4) gone = 1;
        if (st == 7) gone = 0;
        chk("R3 clock release", int'(clk_rel), (st >= 2 && st <= 5) ? 1 : 0);
        chk("R5 bias enable", int'(bias_en), gone ? 0 : 1);
        chk("R10 exit request", int'(exit_req), (st == 8) ? 1 : 0);
        pre_st = st;
    endtask

    task automatic step();
        us_tick = (cyc % 4 == 0);
        cyc++;
        p_l1 = l1_entered; p_en11 = l11_en; p_en12 = l12_en; p_train = train;
        p_permit = permit; p_wake = txn | partner; p_ref = refclk; p_ramp = rampd;
        p_tick = us_tick; p_hold = int'(cm_hold); p_pon = int'(pon);
        @(posedge clk);
        @(negedge clk);
        mon();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd51713);
        rst = 1; l1_entered = 0; us_tick = 0; l11_en = 0; l12_en = 0; train = 0;
        permit = 0; txn = 0; partner = 0; refclk = 0; rampd = 0; cm_hold = '0; pon = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(substate), 0);
        chk("R1 release", int'(clk_rel), 0);
        chk("R1 bias", int'(bias_en), 1);
        chk("R1 exit", int'(exit_req), 0);
        rst = 0;
        pre_st = 0; gone = 0;

        // first stage, second stage blocked
        l1_entered = 1; l11_en = 1; cm_hold = 8'd3; pon = 10'd2;
        steps(10);
        chk("R3 reach L1.1", int'(substate), 2);
        l12_en = 1; permit = 1; train = 1;
        steps(20);
        chk("R4 training blocks", int'(substate), 2);
        train = 0; permit = 0;
        steps(10);
        chk("R4 no permit stays", int'(substate), 2);
        permit = 1;
        steps(40);
        chk("R6 ramp waits", int'(substate), 4);
        chk("R5 bias removed", int'(bias_en), 0);
        rampd = 1; steps(2); rampd = 0;
        chk("R6 bias-off idle", int'(substate), 5);
        // wake from deepest stage
        partner = 1; step(); partner = 0;
        chk("R7 clock re-request", int'(substate), 6);
        chk("R7 release low", int'(clk_rel), 0);
        steps(10);
        chk("R8 waits refclk", int'(substate), 6);
        chk("R8 bias still off", int'(bias_en), 0);
        refclk = 1; step();
        chk("R8 to bias restore", int'(substate), 7);
        steps(20);
        chk("R9 restore done", int'(substate), 8);
        chk("R10 exit high", int'(exit_req), 1);
        l1_entered = 0; step(); refclk = 0;
        chk("R10 back to L0", int'(substate), 0);

        // abort during hold: bias never removed
        l1_entered = 1; cm_hold = 8'd20;
        steps(6);
        chk("R5 in hold", int'(substate), 3);
        txn = 1; step(); txn = 0;
        chk("R7 abort hold", int'(substate), 6);
        chk("R5 bias kept", int'(bias_en), 1);
        refclk = 1; step();
        chk("R8 skip bias wait", int'(substate), 8);
        l1_entered = 0; step(); refclk = 0;

        // wake in basic L1
        l1_entered = 1; l11_en = 0; steps(3);
        chk("R3 stays L1.0", int'(substate), 1);
        txn = 1; step(); txn = 0;
        chk("R7 direct exit", int'(substate), 8);
        l1_entered = 0; step();
        chk("R2 back to L0", int'(substate), 0);

        // constrained random
        for (int i = 0; i < 20000; i++) begin
            if (pre_st == 0) begin
                cm_hold = HW'($urandom_range(0, 6));
                pon     = PW'($urandom_range(0, 6));
            end
            l1_entered = ($urandom % 32) != 0;
            l11_en  = ($urandom % 8) != 0;
            l12_en  = ($urandom % 6) != 0;
            permit  = ($urandom % 4) != 0;
            train   = ($urandom % 10) == 0;
            txn     = ($urandom % 60) == 0;
            partner = ($urandom % 60) == 0;
            refclk  = ($urandom % 3) == 0;
            rampd   = ($urandom % 4) == 0;
            step();
        end

        summary();
        $finish;
    end
endmodule